// File: doc/BRIEF.md
# Selectable Test Pattern Detector

This block watches a received serial bit stream and checks it against one of thirteen test sequences chosen by a 4-bit code. The choices are a steady all-ones signal, a strict alternation, and a set of maximal-length pseudorandom sequences. One of these is inverted, one is bit-reversed and one has a zero-run limit. The checker predicts each incoming bit with a shift register that takes its seed from the line itself. It declares pattern lock once the prediction has held for a run of bits. While locked it flags and counts each bit that disagrees.

Line decoding and frame alignment happen upstream. A qualifier input marks the bits that hold framing overhead. In framed mode those bits are neither checked nor fed to the predictor. In unframed mode every bit is checked. The 16-bit error total is read as two bytes. Asking for the low byte captures both bytes at once, so the high byte always belongs to the same value.

Bits arrive on a valid/ready stream. `in_ready` is high whenever the block is out of reset, so the block never applies back-pressure. A bit is consumed on every clock edge where `in_valid` is high, and cycles with `in_valid` low change nothing.

Top module: `tpd_top`

## Requirements
- R1: After reset, `sync`, `bit_err`, `cnt_lo` and `cnt_hi` are 0 and `in_ready` is 1.
- R2: A bit is taken only on an edge where `in_valid` is 1. Edges with `in_valid` low change no output except through `cnt_clear`, `rd_lo` and the select inputs.
- R3: `pat_sel` picks the sequence, with history bits x[n-k] and x[n] the new bit. Code 0 is all ones. Code 2: x[n]=x[n-5]^x[n-3]. Code 3: x[n-6]^x[n-5]. Code 4: the inverse of x[n-9]^x[n-5]. Code 5: x[n-9]^x[n-5]. Code 6: x[n-11]^x[n-9]. Code 7: x[n-11]^x[n-2], the bit-reversed form of code 6. Code 8: x[n-15]^x[n-14]. Code 9: x[n-20]^x[n-3]. Code 10: x[n-20]^x[n-17]. Code 11: x[n-23]^x[n-18]. Code 12: x[n] is the inverse of x[n-1].
- R4: Code 1 runs the generator g[n]=g[n-20]^g[n-17]. The line bit equals g[n], except that it is forced to 1 when g[n] is 0 and the 14 generator bits before it were all 0.
- R5: While out of lock, `sync` rises on the edge that takes the 64th consecutive checked bit matching the prediction. The first prediction after reset for code 0 is 1.
- R6: Checked bits after lock form back-to-back windows of 64, the first starting with the first bit after lock. The edge that takes the 16th mismatch of a window clears `sync`. A window with 15 mismatches keeps lock.
- R7: `bit_err` is 1 for the one cycle after an edge that took a mismatching checked bit while `sync` was 1. Mismatches taken while `sync` is 0 never raise it.
- R8: With `framed`=1, a bit taken with `frame_slot`=1 is not checked and does not advance the predictor. With `framed`=0, `frame_slot` is ignored.
- R9: The error count rises by one with each `bit_err` pulse and holds at 0xFFFF.
- R10: `cnt_clear` sets the count to 0 on the next edge and overrides an increment on that same edge.
- R11: A change of `pat_sel` or `framed` clears `sync` on the next edge and restarts acquisition.
- R12: On an edge with `rd_lo`=1, `cnt_hi`/`cnt_lo` load the count's high and low bytes together. They hold those values until the next `rd_lo`.
- R13: Codes 13 to 15 behave as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received bit present |
| in_bit | input | 1 | Received bit value |
| in_ready | output | 1 | Always 1 out of reset |
| frame_slot | input | 1 | Current bit is framing overhead |
| pat_sel | input | 4 | Pattern select code |
| framed | input | 1 | 1: skip framing bits, 0: check all bits |
| cnt_clear | input | 1 | Zero the error count |
| rd_lo | input | 1 | Low-byte read strobe; captures both bytes |
| sync | output | 1 | Pattern lock |
| bit_err | output | 1 | Error pulse for a mismatching bit while locked |
| cnt_lo | output | 8 | Captured count, low byte |
| cnt_hi | output | 8 | Captured count, high byte |

## Verification
A wrong tap or a wrong inversion in the predictor shows at the ports in one of two ways. Either `sync` never rises within a few hundred bits of the correct sequence, or lock is reached on a sequence it should reject. A fault in the lock or window counters moves the edge where `sync` changes by at least one bit. Sending 63 or 64 matching bits, or 15 or 16 errors aligned to a window, exposes it on the exact cycle. Faults in the error counter or the capture register stay hidden until the next `rd_lo`. Each error test therefore ends with a read of an exact expected total.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

  typedef enum logic [3:0] {
    PAT_ONES    = 4'd0,
    PAT_QRSS    = 4'd1,
    PAT_P5      = 4'd2,
    PAT_P6      = 4'd3,
    PAT_P9_INV  = 4'd4,
    PAT_P9      = 4'd5,
    PAT_P11     = 4'd6,
    PAT_P11_REV = 4'd7,
    PAT_P15     = 4'd8,
    PAT_P20_A   = 4'd9,
    PAT_P20_B   = 4'd10,
    PAT_P23     = 4'd11,
    PAT_ALT     = 4'd12
  } pat_e;

  // Taps are shift-register positions, where position 0 holds the newest bit.
  typedef struct packed {
    logic       inv;
    logic [4:0] tap_a;
    logic [4:0] tap_b;
  } tap_t;

  function automatic tap_t mk_tap(logic [4:0] a, logic [4:0] b, logic inv);
    tap_t t;
    t.inv   = inv;
    t.tap_a = a;
    t.tap_b = b;
    return t;
  endfunction

  function automatic tap_t tap_of(logic [3:0] code);
    case (code)
      PAT_QRSS:    return mk_tap(5'd19, 5'd16, 1'b0);
      PAT_P5:      return mk_tap(5'd4,  5'd2,  1'b0);
      PAT_P6:      return mk_tap(5'd5,  5'd4,  1'b0);
      PAT_P9_INV:  return mk_tap(5'd8,  5'd4,  1'b1);
      PAT_P9:      return mk_tap(5'd8,  5'd4,  1'b0);
      PAT_P11:     return mk_tap(5'd10, 5'd8,  1'b0);
      PAT_P11_REV: return mk_tap(5'd10, 5'd1,  1'b0);
      PAT_P15:     return mk_tap(5'd14, 5'd13, 1'b0);
      PAT_P20_A:   return mk_tap(5'd19, 5'd2,  1'b0);
      PAT_P20_B:   return mk_tap(5'd19, 5'd16, 1'b0);
      PAT_P23:     return mk_tap(5'd22, 5'd17, 1'b0);
      default:     return mk_tap(5'd0,  5'd0,  1'b0);
    endcase
  endfunction

endpackage

// File: rtl/tpd_predictor.sv
module tpd_predictor
  import tpd_pkg::*;
#(
  parameter int SR_W     = 23,
  parameter int ZRUN_MAX = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] code,
  input  logic       shift_en,
  input  logic       locked,
  input  logic       in_bit,
  output logic       exp_bit
);
  localparam int ZW = $clog2(ZRUN_MAX + 1);

  logic [SR_W-1:0] sr;
  logic [ZW-1:0]   zrun;
  tap_t            tp;
  logic            raw;
  logic            gen_bit;
  logic            store;

  always_comb begin
    tp  = tap_of(code);
    raw = sr[tp.tap_a] ^ sr[tp.tap_b];
    case (code)
      PAT_ALT:  exp_bit = ~sr[0];
      PAT_QRSS: exp_bit = raw | (zrun == ZW'(ZRUN_MAX));
      PAT_P5, PAT_P6, PAT_P9_INV, PAT_P9, PAT_P11, PAT_P11_REV,
      PAT_P15, PAT_P20_A, PAT_P20_B, PAT_P23:
                exp_bit = raw ^ tp.inv;
      default:  exp_bit = 1'b1;
    endcase
    // The zero-limited sequence keeps raw generator bits, not line bits.
    gen_bit = (code == PAT_QRSS) ? raw : exp_bit;
    store   = locked ? gen_bit : in_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr   <= '0;
      zrun <= '0;
    end else if (shift_en) begin
      sr <= {sr[SR_W-2:0], store};
      if (store)                        zrun <= '0;
      else if (zrun != ZW'(ZRUN_MAX))   zrun <= zrun + ZW'(1);
    end
  end

endmodule

// File: rtl/tpd_sync.sv
module tpd_sync #(
  parameter int SYNC_RUN  = 64,
  parameter int WIN_LEN   = 64,
  parameter int LOSS_ERRS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic chk,
  input  logic mism,
  output logic locked
);
  localparam int RUN_W = $clog2(SYNC_RUN);
  localparam int WIN_W = $clog2(WIN_LEN);
  localparam int ERR_W = $clog2(LOSS_ERRS + 1);

  logic [RUN_W-1:0] run;
  logic [WIN_W-1:0] win;
  logic [ERR_W-1:0] werr;
  logic [ERR_W-1:0] werr_n;

  assign werr_n = werr + ERR_W'(mism);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      locked <= 1'b0;
      run    <= '0;
      win    <= '0;
      werr   <= '0;
    end else if (chk) begin
      if (!locked) begin
        if (mism) begin
          run <= '0;
        end else if (run == RUN_W'(SYNC_RUN - 1)) begin
          locked <= 1'b1;
          run    <= '0;
          win    <= '0;
          werr   <= '0;
        end else begin
          run <= run + RUN_W'(1);
        end
      end else if (werr_n == ERR_W'(LOSS_ERRS)) begin
        locked <= 1'b0;
        run    <= '0;
      end else if (win == WIN_W'(WIN_LEN - 1)) begin
        win  <= '0;
        werr <= '0;
      end else begin
        win  <= win + WIN_W'(1);
        werr <= werr_n;
      end
    end
  end

endmodule

// File: rtl/tpd_errcnt.sv
module tpd_errcnt #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              clr,
  input  logic              rd_lo,
  output logic [2*BYTE_W-1:0] count,
  output logic [2*BYTE_W-1:0] snap
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [CNT_W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      snap  <= '0;
    end else begin
      if (clr)                       count <= '0;
      else if (inc && count != MAXV) count <= count + CNT_W'(1);
      if (rd_lo)                     snap  <= count;
    end
  end

endmodule

// File: rtl/tpd_top.sv
module tpd_top
  import tpd_pkg::*;
#(
  parameter int SR_W      = 23,
  parameter int ZRUN_MAX  = 14,
  parameter int SYNC_RUN  = 64,
  parameter int WIN_LEN   = 64,
  parameter int LOSS_ERRS = 16,
  parameter int BYTE_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_bit,
  output logic              in_ready,
  input  logic              frame_slot,
  input  logic [3:0]        pat_sel,
  input  logic              framed,
  input  logic              cnt_clear,
  input  logic              rd_lo,
  output logic              sync,
  output logic              bit_err,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [4:0]       cfg_q;
  logic             restart;
  logic             chk;
  logic             exp_bit;
  logic             mism;
  logic             err_d;
  logic [CNT_W-1:0] err_count;
  logic [CNT_W-1:0] err_snap;

  assign in_ready = 1'b1;
  assign restart  = ({pat_sel, framed} != cfg_q);
  assign chk      = in_valid & ~(framed & frame_slot);
  assign mism     = chk & (in_bit != exp_bit);
  assign err_d    = mism & sync & ~restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      bit_err <= 1'b0;
    end else begin
      cfg_q   <= {pat_sel, framed};
      bit_err <= err_d;
    end
  end

  tpd_predictor #(.SR_W(SR_W), .ZRUN_MAX(ZRUN_MAX)) u_pred (
    .clk(clk), .rst_n(rst_n), .code(pat_sel), .shift_en(chk),
    .locked(sync), .in_bit(in_bit), .exp_bit(exp_bit)
  );

  tpd_sync #(.SYNC_RUN(SYNC_RUN), .WIN_LEN(WIN_LEN), .LOSS_ERRS(LOSS_ERRS)) u_sync (
    .clk(clk), .rst_n(rst_n), .restart(restart), .chk(chk),
    .mism(mism), .locked(sync)
  );

  tpd_errcnt #(.BYTE_W(BYTE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(err_d), .clr(cnt_clear),
    .rd_lo(rd_lo), .count(err_count), .snap(err_snap)
  );

  assign cnt_lo = err_snap[BYTE_W-1:0];
  assign cnt_hi = err_snap[CNT_W-1:BYTE_W];

endmodule

// File: rtl/tpd_checker.sv
module tpd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [3:0]  pat_sel,
  input logic        framed,
  input logic        cnt_clear,
  input logic        rd_lo,
  input logic        sync,
  input logic        bit_err,
  input logic [7:0]  cnt_lo,
  input logic [7:0]  cnt_hi,
  input logic [15:0] count
);

  AST_ERR_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> $past(sync)); // R7

  AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> !bit_err); // R2

  AST_LOCK_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> $past(in_valid)); // R5

  AST_CFG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ({pat_sel, framed} != $past({pat_sel, framed})) |=> !sync); // R11

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> (count == 16'd0)); // R10

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cnt_clear) && count != $past(count)) |->
      (bit_err && count == $past(count) + 16'd1)); // R9

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_lo) |-> $stable({cnt_hi, cnt_lo})); // R12

endmodule

bind tpd_top tpd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pat_sel(pat_sel),
  .framed(framed), .cnt_clear(cnt_clear), .rd_lo(rd_lo), .sync(sync),
  .bit_err(bit_err), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .count(err_count)
);

// File: tb/sim_tpd_top.sv
module sim_tpd_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, in_valid, in_bit, frame_slot, framed, cnt_clear, rd_lo;
  logic [3:0] pat_sel;
  logic       in_ready, sync, bit_err;
  logic [7:0] cnt_lo, cnt_hi;

  logic       s_valid, s_bit, s_rd;
  logic       s_rdy, s_sync, s_err;
  logic [7:0] s_lo, s_hi;

  tpd_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .frame_slot(frame_slot), .pat_sel(pat_sel),
    .framed(framed), .cnt_clear(cnt_clear), .rd_lo(rd_lo), .sync(sync),
    .bit_err(bit_err), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi)
  );

  // Second copy with loss threshold equal to the window, so saturation is reachable.
  tpd_top #(.LOSS_ERRS(64)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_bit(s_bit),
    .in_ready(s_rdy), .frame_slot(1'b0), .pat_sel(4'd0), .framed(1'b0),
    .cnt_clear(1'b0), .rd_lo(s_rd), .sync(s_sync), .bit_err(s_err),
    .cnt_lo(s_lo), .cnt_hi(s_hi)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] h;
  int zr;
  logic [15:0] v;
  logic b;
  logic seen;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic send(input logic bv, input logic slot);
    in_valid = 1'b1; in_bit = bv; frame_slot = slot;
    tick();
    in_valid = 1'b0; frame_slot = 1'b0; cnt_clear = 1'b0;
  endtask

  function automatic int tap_a(input int c);
    case (c)
      1: return 20; 2: return 5; 3: return 6; 4: return 9; 5: return 9;
      6: return 11; 7: return 11; 8: return 15; 9: return 20; 10: return 20;
      default: return 23;
    endcase
  endfunction

  function automatic int tap_b(input int c);
    case (c)
      1: return 17; 2: return 3; 3: return 5; 4: return 5; 5: return 5;
      6: return 9; 7: return 2; 8: return 14; 9: return 3; 10: return 17;
      default: return 18;
    endcase
  endfunction

  task automatic gen_next(input int c, output logic o);
    logic g;
    if (c == 1) begin
      g = h[tap_a(c)-1] ^ h[tap_b(c)-1];
      o = g | (zr >= 14);
      h = {h[30:0], g};
      zr = g ? 0 : zr + 1;
    end else if (c >= 2 && c <= 11) begin
      g = h[tap_a(c)-1] ^ h[tap_b(c)-1];
      if (c == 4) g = ~g;
      o = g;
      h = {h[30:0], g};
    end else if (c == 12) begin
      o = ~h[0];
      h = {h[30:0], o};
    end else begin
      o = 1'b1;
    end
  endtask

  task automatic feed(input int c, input int n);
    logic o;
    for (int i = 0; i < n; i++) begin
      gen_next(c, o);
      send(o, 1'b0);
    end
  endtask

  task automatic flips(input int c, input int n);
    logic o;
    for (int i = 0; i < n; i++) begin
      gen_next(c, o);
      send(~o, 1'b0);
    end
  endtask

  task automatic read16(output logic [15:0] r);
    rd_lo = 1'b1;
    tick();
    rd_lo = 1'b0;
    r = {cnt_hi, cnt_lo};
  endtask

  task automatic do_clear();
    cnt_clear = 1'b1;
    tick();
    cnt_clear = 1'b0;
  endtask

  task automatic select(input int c, input logic fr);
    pat_sel = 4'(c);
    framed = fr;
    tick();
    h = '1;
    zr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_bit = 1'b0; frame_slot = 1'b0;
    framed = 1'b0; cnt_clear = 1'b0; rd_lo = 1'b0; pat_sel = 4'd0;
    s_valid = 1'b0; s_bit = 1'b0; s_rd = 1'b0;
    h = '1; zr = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();

    // R1 reset state
    check("R1 sync", sync, 0);
    check("R1 bit_err", bit_err, 0);
    check("R1 count", {cnt_hi, cnt_lo}, 0);
    check("R1 in_ready", in_ready, 1);

    // R5 lock on exactly the 64th matching bit
    for (int i = 0; i < 63; i++) send(1'b1, 1'b0);
    check("R5 after 63", sync, 0);
    send(1'b1, 1'b0);
    check("R5 after 64", sync, 1);

    // R2 idle cycles with a wrong data value change nothing
    seen = 1'b0;
    in_bit = 1'b0;
    for (int i = 0; i < 10; i++) begin
      tick();
      if (bit_err) seen = 1'b1;
    end
    check("R2 no error while idle", seen, 0);
    check("R2 lock kept", sync, 1);
    read16(v);
    check("R2 count", v, 0);

    // R3 R4 R13 every code locks and stays error-free; R11 restart on change
    for (int c = 0; c < 16; c++) begin
      string tag;
      tag = (c == 1) ? "R4" : ((c > 12) ? "R13" : "R3");
      if (c != 0) begin
        select(c, 1'b0);
        check("R11 restart", sync, 0);
      end
      h = '1; zr = 0;
      feed(c, 400);
      check(tag, sync, 1);
      do_clear();
      feed(c, 200);
      read16(v);
      check(tag, v, 0);
    end

    // R3 reversed and inverted codes reject their neighbours
    select(7, 1'b0);
    feed(6, 400);
    check("R3 reversed rejects forward", sync, 0);
    select(4, 1'b0);
    feed(5, 400);
    check("R3 inverted rejects plain", sync, 0);

    // R7 R9 single error
    select(8, 1'b0);
    feed(8, 300);
    check("R3 lock 2^15", sync, 1);
    do_clear();
    flips(8, 1);
    check("R7 pulse", bit_err, 1);
    feed(8, 1);
    check("R7 one cycle", bit_err, 0);
    read16(v);
    check("R9 one error", v, 1);

    // R7 errors while hunting are not reported
    select(5, 1'b0);
    seen = 1'b0;
    for (int i = 0; i < 40; i++) begin
      send(1'(i), 1'b0);
      if (bit_err) seen = 1'b1;
    end
    check("R7 silent while hunting", seen, 0);
    read16(v);
    check("R9 unchanged while hunting", v, 1);

    // R6 window loss rule
    select(8, 1'b0);
    for (int i = 0; i < 500 && !sync; i++) begin
      gen_next(8, b);
      send(b, 1'b0);
    end
    check("R5 reacquire", sync, 1);
    do_clear();
    flips(8, 15);
    check("R6 15 errors keep lock", sync, 1);
    feed(8, 49);
    flips(8, 15);
    check("R6 next window keeps lock", sync, 1);
    feed(8, 49);
    flips(8, 15);
    check("R6 15 of window", sync, 1);
    flips(8, 1);
    check("R6 16th error drops lock", sync, 0);
    read16(v);
    check("R9 counted 46", v, 46);

    // R8 framed mode skips overhead bits
    select(8, 1'b1);
    for (int i = 0; i < 600; i++) begin
      if (i % 10 == 9) send(1'(i / 10), 1'b1);
      else begin
        gen_next(8, b);
        send(b, 1'b0);
      end
      if (i == 399) do_clear();
    end
    check("R8 framed lock", sync, 1);
    send(1'b0, 1'b1);
    check("R8 slot 0 unchecked", bit_err, 0);
    send(1'b1, 1'b1);
    check("R8 slot 1 unchecked", bit_err, 0);
    feed(8, 5);
    read16(v);
    check("R8 framed count", v, 0);

    // R8 unframed mode checks slot bits too
    select(8, 1'b0);
    feed(8, 300);
    do_clear();
    flips(8, 0);
    gen_next(8, b);
    send(~b, 1'b1);
    check("R8 unframed slot checked", bit_err, 1);
    gen_next(8, b);
    send(b, 1'b1);
    check("R8 unframed slot match", bit_err, 0);

    // R10 clear wins over increment
    gen_next(8, b);
    cnt_clear = 1'b1;
    send(~b, 1'b0);
    check("R10 pulse still shown", bit_err, 1);
    read16(v);
    check("R10 clear wins", v, 0);

    // R12 captured value holds until next read
    flips(8, 3);
    read16(v);
    check("R12 read 3", v, 3);
    flips(8, 2);
    check("R12 holds", {cnt_hi, cnt_lo}, 3);
    read16(v);
    check("R12 read 5", v, 5);

    // R9 saturation on the second copy
    for (int i = 0; i < 64; i++) begin
      s_valid = 1'b1; s_bit = 1'b1;
      tick();
    end
    check("R5 second copy lock", s_sync, 1);
    for (int w = 0; w < 1050; w++) begin
      for (int k = 0; k < 64; k++) begin
        s_bit = (k == 63);
        tick();
      end
    end
    s_valid = 1'b0;
    s_rd = 1'b1;
    tick();
    s_rd = 1'b0;
    check("R9 saturates", {s_hi, s_lo}, 16'hFFFF);
    check("R6 63 of 64 keeps lock", s_sync, 1);

    finish_run();
  end

endmodule